// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Control

This block is the hazard control of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and write-back. It has no registers. Every cycle it compares the source register numbers of the instructions in decode and execute against the destination fields held in the three pipeline registers downstream. From that comparison it drives the two ALU operand multiplexer selects and a set of stall strobes.

Forwarding covers two distances. A result waiting in the execute/memory register goes to the instruction right behind its producer. A result waiting in the memory/write-back register goes to the instruction two slots behind. When both registers hold the same destination, the newer one wins.

A load cannot forward its value to the instruction right behind it. When that instruction needs the loaded register, the block raises three strobes together for one cycle: it freezes the PC, freezes the fetch/decode register, and turns the decode/execute entry into a bubble. Instructions three or more slots behind a producer get their value through the register file, which writes before it reads within a cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An execute-stage source equal to the execute/memory destination gets select 2'b10 on its operand. This holds only when that destination is nonzero and its write flag is set.
- R2: An execute-stage source equal to a nonzero, write-enabled memory/write-back destination gets select 2'b01. This applies only when R1 does not apply to that operand.
- R3: When both downstream registers match the same source, the select is 2'b10, so the newest result wins.
- R4: With no qualifying match the select is 2'b00, meaning the register file. This covers three rules: register 0 never forwards, a producer with a clear write flag is ignored, and a producer three slots ahead is served by write-then-read in the register file.
- R5: If decode/execute holds a load with its write flag set and a nonzero destination equal to either decode source, then hold-PC, hold-fetch/decode and bubble are all 1 in that cycle.
- R6: The three stall strobes are always equal. In a running program each load followed directly by a dependent instruction costs exactly one stall cycle.
- R7: An instruction two slots after a load gets the loaded value through select 2'b01 with no stall.
- R8: No stall comes from a producer that is not a load, from a load to register 0, or from a load whose write flag is clear.
- R9: A program run through a pipeline driven by these controls retires every instruction with the same result as sequential execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 5 | First source register of the instruction in decode |
| idRs2 | input | 5 | Second source register of the instruction in decode |
| exeRs1 | input | 5 | First source register of the instruction in execute |
| exeRs2 | input | 5 | Second source register of the instruction in execute |
| idExeRd | input | 5 | Destination held in decode/execute |
| idExeRegWrite | input | 1 | Register write flag in decode/execute |
| idExeMemRead | input | 1 | Load flag in decode/execute |
| exeMemRd | input | 5 | Destination held in execute/memory |
| exeMemRegWrite | input | 1 | Register write flag in execute/memory |
| memWbRd | input | 5 | Destination held in memory/write-back |
| memWbRegWrite | input | 1 | Register write flag in memory/write-back |
| selA | output | 2 | First ALU operand source: 00 register file, 10 execute/memory, 01 memory/write-back |
| selB | output | 2 | Second ALU operand source, same encoding as selA |
| holdPc | output | 1 | Keep the PC unchanged this cycle |
| holdIfId | output | 1 | Keep the fetch/decode register unchanged this cycle |
| bubbleIdExe | output | 1 | Clear the write and load flags entering decode/execute |

## Verification
A wrong select takes a stale or wrong value into the ALU. The error reaches write-back two cycles later as a result that differs from sequential execution. A missed load-use stall sends the dependent instruction forward with the address computed for the load instead of the loaded data, and that shows at its retirement. An extra or stretched stall shows up as a stall count that differs from the number of adjacent load-use pairs in the program. A loss of priority between the two forwarding sources first shows in an instruction that reuses a register written by both of the two instructions ahead of it.

// File: rtl/pipe_hazard_pkg.sv
`timescale 1ns/1ps
package pipe_hazard_pkg;

  // operand source select encoding driven to the ALU input multiplexers
  typedef enum logic [1:0] {
    OPND_REGFILE = 2'b00,
    OPND_MEMWB   = 2'b01,
    OPND_EXEMEM  = 2'b10
  } opndSrc_e;

  // strobes from the load-use detector to the pipeline registers
  typedef struct packed {
    logic holdPc;
    logic holdIfId;
    logic bubbleIdExe;
  } stallStrobes_t;

endpackage

// File: rtl/operand_forward.sv
`timescale 1ns/1ps
module operand_forward
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] srcReg,
  input  logic [REG_W-1:0]              exeMemRd,
  input  logic                          exeMemRegWrite,
  input  logic [REG_W-1:0]              memWbRd,
  input  logic                          memWbRegWrite,
  output logic [NUM_SRC-1:0][1:0]       opndSel
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exeMemLive;
  logic memWbLive;

  // a producer is eligible only if it writes a real register
  assign exeMemLive = exeMemRegWrite && (exeMemRd != ZERO_REG);
  assign memWbLive  = memWbRegWrite  && (memWbRd  != ZERO_REG);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic     hitExeMem;
      logic     hitMemWb;
      opndSrc_e pick;

      assign hitExeMem = exeMemLive && (exeMemRd == srcReg[s]);
      assign hitMemWb  = memWbLive  && (memWbRd  == srcReg[s]);

      // newest producer first
      always_comb begin
        if (hitExeMem)     pick = OPND_EXEMEM;
        else if (hitMemWb) pick = OPND_MEMWB;
        else               pick = OPND_REGFILE;
      end

      assign opndSel[s] = pick;

      always_comb begin : chk
        assert_sel_legal_R4: assert (opndSel[s] != 2'b11)
          else $error("operand %0d select has unused code", s);
        assert_exemem_owner_R1: assert (opndSel[s] != 2'b10 ||
            (exeMemRegWrite && exeMemRd == srcReg[s] && exeMemRd != ZERO_REG))
          else $error("operand %0d forwarded from EXE/MEM without owner", s);
        assert_newest_wins_R3: assert (opndSel[s] != 2'b01 ||
            !(exeMemRegWrite && exeMemRd == srcReg[s] && exeMemRd != ZERO_REG))
          else $error("operand %0d took older result over newer", s);
      end
    end
  endgenerate

endmodule

// File: rtl/load_use_detect.sv
`timescale 1ns/1ps
module load_use_detect
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] idSrcReg,
  input  logic [REG_W-1:0]              idExeRd,
  input  logic                          idExeRegWrite,
  input  logic                          idExeMemRead,
  output stallStrobes_t                 strobes
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic               loadPending;
  logic [NUM_SRC-1:0] srcHit;
  logic               stallNow;

  assign loadPending = idExeMemRead && idExeRegWrite && (idExeRd != ZERO_REG);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
      assign srcHit[s] = (idSrcReg[s] == idExeRd);
    end
  endgenerate

  assign stallNow = loadPending && (|srcHit);

  always_comb begin
    strobes.holdPc      = stallNow;
    strobes.holdIfId    = stallNow;
    strobes.bubbleIdExe = stallNow;
  end

  always_comb begin : chk
    assert_strobes_agree_R6: assert (strobes.holdPc == strobes.holdIfId &&
                                     strobes.holdIfId == strobes.bubbleIdExe)
      else $error("stall strobes disagree");
    assert_load_only_R8: assert (!strobes.bubbleIdExe ||
                                 (idExeMemRead && idExeRegWrite && idExeRd != ZERO_REG))
      else $error("stall without a qualifying load");
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic [REG_W-1:0] exeRs1,
  input  logic [REG_W-1:0] exeRs2,
  input  logic [REG_W-1:0] idExeRd,
  input  logic             idExeRegWrite,
  input  logic             idExeMemRead,
  input  logic [REG_W-1:0] exeMemRd,
  input  logic             exeMemRegWrite,
  input  logic [REG_W-1:0] memWbRd,
  input  logic             memWbRegWrite,
  output logic [1:0]       selA,
  output logic [1:0]       selB,
  output logic             holdPc,
  output logic             holdIfId,
  output logic             bubbleIdExe
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] exeSrc;
  logic [NUM_SRC-1:0][REG_W-1:0] idSrc;
  logic [NUM_SRC-1:0][1:0]       sel;
  stallStrobes_t                 strobes;

  assign exeSrc = {exeRs2, exeRs1};
  assign idSrc  = {idRs2, idRs1};

  operand_forward #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_fwd (
    .srcReg         (exeSrc),
    .exeMemRd       (exeMemRd),
    .exeMemRegWrite (exeMemRegWrite),
    .memWbRd        (memWbRd),
    .memWbRegWrite  (memWbRegWrite),
    .opndSel        (sel)
  );

  load_use_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_stall (
    .idSrcReg      (idSrc),
    .idExeRd       (idExeRd),
    .idExeRegWrite (idExeRegWrite),
    .idExeMemRead  (idExeMemRead),
    .strobes       (strobes)
  );

  assign selA        = sel[0];
  assign selB        = sel[1];
  assign holdPc      = strobes.holdPc;
  assign holdIfId    = strobes.holdIfId;
  assign bubbleIdExe = strobes.bubbleIdExe;

  always_comb begin : chk
    assert_stall_has_reader_R5: assert (!bubbleIdExe ||
                                        idRs1 == idExeRd || idRs2 == idExeRd)
      else $error("stall raised with no dependent decode source");
  end

endmodule

// File: tb/tb_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] idRs1, idRs2, exeRs1, exeRs2, idExeRd, exeMemRd, memWbRd;
  logic       idExeRegWrite, idExeMemRead, exeMemRegWrite, memWbRegWrite;
  logic [1:0] selA, selB;
  logic       holdPc, holdIfId, bubbleIdExe;

  pipe_hazard_ctrl dut (
    .idRs1(idRs1), .idRs2(idRs2), .exeRs1(exeRs1), .exeRs2(exeRs2),
    .idExeRd(idExeRd), .idExeRegWrite(idExeRegWrite), .idExeMemRead(idExeMemRead),
    .exeMemRd(exeMemRd), .exeMemRegWrite(exeMemRegWrite),
    .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite),
    .selA(selA), .selB(selB), .holdPc(holdPc), .holdIfId(holdIfId),
    .bubbleIdExe(bubbleIdExe)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic driveVec(input logic [4:0] iR1, iR2, eR1, eR2, xRd,
                          input logic xWr, xLd,
                          input logic [4:0] mRd, input logic mWr,
                          input logic [4:0] wRd, input logic wWr);
    @(negedge clk);
    idRs1 = iR1; idRs2 = iR2; exeRs1 = eR1; exeRs2 = eR2;
    idExeRd = xRd; idExeRegWrite = xWr; idExeMemRead = xLd;
    exeMemRd = mRd; exeMemRegWrite = mWr; memWbRd = wRd; memWbRegWrite = wWr;
    #1;
  endtask

  // ---------------- pipeline shell ----------------
  typedef struct packed {
    logic        v, ld, wr;
    logic [4:0]  rd, rs1, rs2;
    logic [31:0] a, b, res;
    logic [15:0] id;
  } slot_t;

  slot_t       prog [0:31];
  int          progLen;
  logic [31:0] rf [0:31];
  slot_t       ifid, idex, exmem, memwb;
  int          pc;
  int          retired;
  int          stallCycles;
  logic [31:0] expQ [$];

  function automatic logic [31:0] loadVal(input logic [31:0] addr);
    return addr * 32'd7 + 32'h100;
  endfunction

  function automatic logic [31:0] initReg(input int r);
    return (r == 0) ? 32'd0 : 32'(r * 3 + 1);
  endfunction

  task automatic addInstr(input logic ld, wr, input logic [4:0] rd, rs1, rs2);
    slot_t s;
    s = '0;
    s.v = 1'b1; s.ld = ld; s.wr = wr; s.rd = rd; s.rs1 = rs1; s.rs2 = rs2;
    s.id = 16'(progLen);
    prog[progLen] = s;
    progLen++;
  endtask

  // driver: sequential reference pushes expected results into the scoreboard
  task automatic pushExpected(output int expStalls);
    logic [31:0] m [0:31];
    for (int r = 0; r < 32; r++) m[r] = initReg(r);
    expStalls = 0;
    for (int i = 0; i < progLen; i++) begin
      logic [31:0] s;
      s = m[prog[i].rs1] + m[prog[i].rs2];
      if (prog[i].ld) s = loadVal(s);
      expQ.push_back(s);
      if (prog[i].wr && prog[i].rd != 0) m[prog[i].rd] = s;
      if (i > 0 && prog[i-1].ld && prog[i-1].wr && prog[i-1].rd != 0 &&
          (prog[i-1].rd == prog[i].rs1 || prog[i-1].rd == prog[i].rs2))
        expStalls++;
    end
  endtask

  function automatic logic [31:0] pickOpnd(input logic [1:0] sel, input logic [31:0] rfVal);
    case (sel)
      2'b10:   return exmem.res;
      2'b01:   return memwb.res;
      default: return rfVal;
    endcase
  endfunction

  // monitor: pop and compare at write-back
  task automatic retire(input slot_t s);
    logic [31:0] exp;
    if (expQ.size() == 0) begin
      check("R9", "unexpected retirement", 32'(s.id), 32'hFFFF);
      return;
    end
    exp = expQ.pop_front();
    check("R9", $sformatf("result of instr %0d", s.id), s.res, exp);
    retired++;
  endtask

  task automatic stepPipe();
    slot_t nEx, nWb, nId;
    logic [31:0] opA, opB;
    @(negedge clk);
    idRs1 = ifid.v ? ifid.rs1 : 5'd0;  idRs2 = ifid.v ? ifid.rs2 : 5'd0;
    exeRs1 = idex.rs1;  exeRs2 = idex.rs2;
    idExeRd = idex.rd;  idExeRegWrite = idex.v & idex.wr;  idExeMemRead = idex.v & idex.ld;
    exeMemRd = exmem.rd; exeMemRegWrite = exmem.v & exmem.wr;
    memWbRd = memwb.rd;  memWbRegWrite = memwb.v & memwb.wr;
    #1;
    if (memwb.v) begin
      retire(memwb);
      if (memwb.wr && memwb.rd != 0) rf[memwb.rd] = memwb.res;
    end
    opA = pickOpnd(selA, idex.a);
    opB = pickOpnd(selB, idex.b);
    nEx = idex; nEx.res = opA + opB;
    nWb = exmem;
    if (exmem.v && exmem.ld) nWb.res = loadVal(exmem.res);
    if (holdPc) begin
      stallCycles++;
      check("R6", "hold IF/ID with hold PC", 32'(holdIfId), 32'd1);
      check("R6", "bubble with hold PC", 32'(bubbleIdExe), 32'd1);
      nId = '0;
    end else begin
      nId = ifid;
      nId.a = rf[ifid.rs1];
      nId.b = rf[ifid.rs2];
      ifid = (pc < progLen) ? prog[pc] : '0;
      pc++;
    end
    idex = nId; exmem = nEx; memwb = nWb;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int expStalls;
    // reset state of the shell: empty pipeline
    ifid = '0; idex = '0; exmem = '0; memwb = '0; pc = 0; retired = 0; stallCycles = 0;
    progLen = 0;
    for (int r = 0; r < 32; r++) rf[r] = initReg(r);
    repeat (3) @(posedge clk);

    driveVec(0,0, 0,0, 0,0,0, 0,0, 0,0);
    check("R4", "reset selA", 32'(selA), 32'd0);
    check("R4", "reset selB", 32'(selB), 32'd0);
    check("R5", "reset holdPc", 32'(holdPc), 32'd0);

    driveVec(0,0, 3,9, 0,0,0, 3,1, 0,0);
    check("R1", "EXE/MEM match selA", 32'(selA), 32'b10);
    check("R1", "unrelated selB", 32'(selB), 32'b00);

    driveVec(0,0, 9,4, 0,0,0, 0,0, 4,1);
    check("R2", "MEM/WB match selB", 32'(selB), 32'b01);

    driveVec(0,0, 6,6, 0,0,0, 6,1, 6,1);
    check("R3", "both match selA", 32'(selA), 32'b10);
    check("R3", "both match selB", 32'(selB), 32'b10);

    driveVec(0,0, 0,0, 0,0,0, 0,1, 0,1);
    check("R4", "register 0 not forwarded", 32'(selA), 32'b00);

    driveVec(0,0, 5,1, 0,0,0, 5,0, 5,1);
    check("R4", "write flag clear ignored", 32'(selA), 32'b01);
    check("R4", "no match selB", 32'(selB), 32'b00);

    driveVec(3,7, 0,0, 7,1,1, 0,0, 0,0);
    check("R5", "load-use holdPc", 32'(holdPc), 32'd1);
    check("R5", "load-use holdIfId", 32'(holdIfId), 32'd1);
    check("R5", "load-use bubble", 32'(bubbleIdExe), 32'd1);

    driveVec(7,2, 0,0, 7,1,1, 0,0, 0,0);
    check("R5", "load-use on first source", 32'(holdPc), 32'd1);

    driveVec(8,9, 0,0, 7,1,1, 0,0, 0,0);
    check("R5", "load without reader", 32'(holdPc), 32'd0);

    driveVec(7,7, 0,0, 7,1,0, 0,0, 0,0);
    check("R8", "ALU producer no stall", 32'(bubbleIdExe), 32'd0);

    driveVec(0,0, 0,0, 0,1,1, 0,0, 0,0);
    check("R8", "load to r0 no stall", 32'(holdIfId), 32'd0);

    driveVec(7,7, 0,0, 7,0,1, 0,0, 0,0);
    check("R8", "load with write clear", 32'(holdPc), 32'd0);

    driveVec(12,3, 12,1, 2,1,0, 0,0, 12,1);
    check("R7", "two after load selA", 32'(selA), 32'b01);
    check("R7", "two after load no stall", 32'(holdPc), 32'd0);

    // program through the shell
    addInstr(0,1, 1, 2, 3);
    addInstr(0,1, 4, 1, 2);
    addInstr(0,1, 3, 5, 1);
    addInstr(0,1, 6, 1, 2);
    addInstr(0,1, 1, 1, 1);
    addInstr(0,1, 1, 1, 7);
    addInstr(0,1, 8, 1, 1);
    addInstr(1,1, 9, 1, 0);
    addInstr(0,1, 10, 9, 2);
    addInstr(0,1, 11, 9, 9);
    addInstr(1,1, 12, 2, 3);
    addInstr(0,1, 13, 1, 2);
    addInstr(0,1, 14, 12, 0);
    addInstr(1,1, 0, 1, 0);
    addInstr(0,1, 15, 0, 1);
    addInstr(1,0, 5, 1, 1);
    addInstr(0,1, 16, 5, 1);
    pushExpected(expStalls);
    for (int c = 0; c < progLen + 12; c++) stepPipe();
    check("R9", "instructions retired", 32'(retired), 32'(progLen));
    check("R6", "stall cycles in program", 32'(stallCycles), 32'(expStalls));
    check("R7", "r14 holds second load", rf[14], rf[12]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule